// File: doc/BRIEF.md
# Masked Change-Detect Interrupt Controller

The block watches a group of general-purpose I/O pins. It raises an active-low, open-drain interrupt request when the value of any enabled pin has moved away from a stored reference. Each pin passes through a synchronizer first. Its synchronized value is compared with the reference taken at the last read of the I/O data register. A per-pin mask register decides which pins may raise the request.

Software clears the request by reading the I/O data register; no separate acknowledge exists. The same read copies the current synchronized pin values into the reference. The request is sticky: a pin that changes and then returns to its old value before the read still leaves the request asserted. The open-drain output is modelled as an enable. When it is high, the pad is pulled low; otherwise the pad is released.

Top module: `chgint_ctrl`

## Requirements
- R1: After reset, every mask bit reads as 1 (pin masked), the reference and the synchronized pin values are all 0, and `irq_oe_o` is 0.
- R2: `rd_data_o` shows the pin inputs delayed by exactly two rising clock edges, through a two-flop synchronizer.
- R3: When an unmasked pin changes in either direction relative to the reference, `irq_oe_o` rises after the second rising edge that follows the input change.
- R4: A pin whose mask bit is 1 never causes `irq_oe_o` to assert, whatever its activity.
- R5: A cycle with `rd_read_i` high clears the pending request and loads the reference from `rd_data_o` at that clock edge. `irq_oe_o` is 0 right after that edge if no enabled pin changes at it.
- R6: Once asserted, `irq_oe_o` stays asserted until a read, even if the pin that caused it returns to its reference value.
- R7: If an unmasked synchronized pin changes at the same edge as a clearing read, `irq_oe_o` stays asserted after that edge.
- R8: A mask write (`mask_we_i` high, bit i = 1 masks pin i) takes effect at the next edge. Unmasking a pin that differs from the reference asserts `irq_oe_o` after that edge. Masking a pin does not withdraw a request that has already been latched for at least one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Raw I/O pin values (asynchronous) |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | NPINS | Mask write data, 1 = pin masked |
| rd_read_i | input | 1 | I/O data register read strobe |
| rd_data_o | output | NPINS | Synchronized pin values (I/O data register) |
| irq_oe_o | output | 1 | Interrupt pull-down enable, 1 = pad driven low |

## Verification
A pin change reaches `rd_data_o` and the live compare two edges after it is driven. The bench therefore drives every input on a falling edge and checks one falling edge later (still absent) and two falling edges later (present). Reads and mask writes act at the single rising edge they straddle, so their effect is checked on the next falling edge. The coincident-read case places the strobe one cycle after the pin change, so that the read edge and the synchronizer's second edge are the same edge.

// File: rtl/chgint_pkg.sv
package chgint_pkg;
  localparam int unsigned DEF_PINS  = 12;
  localparam int unsigned DEF_SYNC  = 2;
endpackage

// File: rtl/chgint_sync.sv
module chgint_sync #(
  parameter int unsigned W      = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/chgint_maskreg.sv
module chgint_maskreg #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  // all pins masked out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '1;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/chgint_detect.sv
module chgint_detect #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_s_i,
  input  logic [W-1:0] mask_i,
  input  logic         load_i,
  output logic         live_o
);
  logic [W-1:0] ref_q;
  logic [W-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ref_q <= '0;
    else if (load_i) ref_q <= pins_s_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign hit[i] = (pins_s_i[i] ^ ref_q[i]) & ~mask_i[i];
  end

  assign live_o = |hit;
endmodule

// File: rtl/chgint_irq.sv
module chgint_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic live_i,
  input  logic clr_i,
  output logic irq_o
);
  logic pend_q;

  // read wins over the latch; a change at the read edge re-raises via live_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (clr_i)  pend_q <= 1'b0;
    else if (live_i) pend_q <= 1'b1;
  end

  assign irq_o = pend_q | live_i;
endmodule

// File: rtl/chgint_ctrl.sv
module chgint_ctrl
  import chgint_pkg::*;
#(
  parameter int unsigned NPINS = DEF_PINS,
  parameter int unsigned SYNC  = DEF_SYNC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pins_i,
  input  logic             mask_we_i,
  input  logic [NPINS-1:0] mask_wdata_i,
  input  logic             rd_read_i,
  output logic [NPINS-1:0] rd_data_o,
  output logic             irq_oe_o
);
  logic [NPINS-1:0] pins_s;
  logic [NPINS-1:0] mask_q;
  logic             live;

  chgint_sync #(.W(NPINS), .STAGES(SYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (pins_s)
  );

  chgint_maskreg #(.W(NPINS)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_q)
  );

  chgint_detect #(.W(NPINS)) u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pins_s_i (pins_s),
    .mask_i   (mask_q),
    .load_i   (rd_read_i),
    .live_o   (live)
  );

  chgint_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .live_i (live),
    .clr_i  (rd_read_i),
    .irq_o  (irq_oe_o)
  );

  assign rd_data_o = pins_s;
endmodule

// File: rtl/chgint_ctrl_chk.sv
module chgint_ctrl_chk #(
  parameter int unsigned NPINS = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPINS-1:0] pins_i,
  input logic             mask_we_i,
  input logic             rd_read_i,
  input logic [NPINS-1:0] rd_data_o,
  input logic [NPINS-1:0] mask_q,
  input logic             irq_oe_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (rd_data_o == $past(pins_i, 2)));

  // R3
  unmasked_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q >= 2'd1) && $stable(mask_q) &&
     (|((rd_data_o ^ $past(rd_data_o)) & ~mask_q))) |-> irq_oe_o);

  // R4
  all_masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_oe_o && (&mask_q) && !mask_we_i) |=> !irq_oe_o);

  // R6
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_oe_o && !rd_read_i) |=> irq_oe_o);

  // R5
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_read_i && !mask_we_i) |=>
      (irq_oe_o == (|((rd_data_o ^ $past(rd_data_o)) & ~mask_q))));
endmodule

bind chgint_ctrl chgint_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pins_i    (pins_i),
  .mask_we_i (mask_we_i),
  .rd_read_i (rd_read_i),
  .rd_data_o (rd_data_o),
  .mask_q    (mask_q),
  .irq_oe_o  (irq_oe_o)
);

// File: tb/chgint_ctrl_tb_top.sv
module chgint_ctrl_tb_top;
  localparam int unsigned NP     = 12;
  localparam time         CLK_T  = 10ns;
  localparam int unsigned WD_MAX = 5000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          m_we = 1'b0;
  logic [NP-1:0] m_wd = '0;
  logic          rd = 1'b0;
  logic [NP-1:0] rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_T/2) clk = ~clk;

  chgint_ctrl #(.NPINS(NP)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pins_i       (pins),
    .mask_we_i    (m_we),
    .mask_wdata_i (m_wd),
    .rd_read_i    (rd),
    .rd_data_o    (rdata),
    .irq_oe_o     (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1; cyc(1); rd = 1'b0;
  endtask

  task automatic wr_mask(input logic [NP-1:0] v);
    m_we = 1'b1; m_wd = v; cyc(1); m_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", irq, 0);
    chk("R1 data after reset", rdata, 0);
  endtask

  task automatic t_masked_default();
    pins = 12'hFFF;
    cyc(1);
    chk("R2 data not yet after 1 edge", rdata, 12'h000);
    cyc(1);
    chk("R2 data after 2 edges", rdata, 12'hFFF);
    cyc(2);
    chk("R1 all masked, no irq", irq, 0);
    do_read();
    chk("R5 read with no change", irq, 0);
  endtask

  task automatic t_unmask_equal();
    wr_mask('0);
    chk("R8 unmask with pins equal ref", irq, 0);
  endtask

  task automatic t_fall();
    pins[3] = 1'b0;
    cyc(1);
    chk("R3 falling not yet", irq, 0);
    cyc(1);
    chk("R3 falling asserted", irq, 1);
    cyc(2);
    do_read();
    chk("R5 read clears", irq, 0);
    chk("R2 data after fall", rdata, 12'hFF7);
  endtask

  task automatic t_rise();
    pins[3] = 1'b1;
    cyc(2);
    chk("R3 rising asserted", irq, 1);
    do_read();
    chk("R5 read clears rise", irq, 0);
  endtask

  task automatic t_sticky();
    pins[5] = 1'b0;
    cyc(2);
    chk("R6 initial assert", irq, 1);
    pins[5] = 1'b1;
    cyc(4);
    chk("R6 held after revert", irq, 1);
    do_read();
    chk("R6 cleared by read", irq, 0);
  endtask

  task automatic t_masked_pin();
    wr_mask(12'h001);
    pins[0] = 1'b0;
    cyc(4);
    chk("R4 masked pin ignored", irq, 0);
    pins[0] = 1'b1;
    cyc(3);
    chk("R4 masked pin ignored again", irq, 0);
  endtask

  task automatic t_coincident();
    pins[7] = 1'b0;
    cyc(1);
    rd = 1'b1; cyc(1); rd = 1'b0;
    chk("R7 change at read edge keeps irq", irq, 1);
    chk("R7 data shows new value", rdata, 12'hF7F);
    do_read();
    chk("R7 second read clears", irq, 0);
  endtask

  task automatic t_mask_late();
    pins[9] = 1'b0;
    cyc(3);
    chk("R8 pending before mask", irq, 1);
    wr_mask(12'h201);
    chk("R8 latched survives masking", irq, 1);
    do_read();
    chk("R8 read clears masked", irq, 0);
  endtask

  task automatic t_unmask_diff();
    pins[9] = 1'b1;
    cyc(3);
    chk("R4 masked pin 9 ignored", irq, 0);
    wr_mask(12'h001);
    chk("R8 unmask differing pin asserts", irq, 1);
    do_read();
    chk("R5 final clear", irq, 0);
  endtask

  initial begin : wd
    for (int i = 0; i < WD_MAX && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", WD_MAX);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_masked_default();
    t_unmask_equal();
    t_fall();
    t_rise();
    t_sticky();
    t_masked_pin();
    t_coincident();
    t_mask_late();
    t_unmask_diff();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule